// File: doc/BRIEF.md
# 64-bit Integer Execute Unit with Word Operations

This block is the purely combinational integer arithmetic stage of a 64-bit RISC-V style core. For a decoded arithmetic instruction it takes the first source value, the second source value and the already sign-extended immediate, along with the funct3 and funct7 fields. Two mode bits tell it whether the instruction is in register or immediate form and whether it is a full-width or a 32-bit word operation. It returns the 64-bit result in the same cycle, and it raises a flag when the funct3/funct7 pair does not name a supported operation.

Full-width operations are addition, subtraction, XOR, OR, AND, signed and unsigned set-less-than, and left, logical-right and arithmetic-right shifts. The word forms cover add, subtract and the three shifts. They work on the low 32 bits and always return a value sign-extended from bit 31. Shift amounts are masked to 6 bits in full-width operations and to 5 bits in word operations.

Top module: `int_exec_unit`

## Requirements
- R1: With `imm_sel`=1 the second operand is `imm_val`, and `src_b` has no effect. With `imm_sel`=0 the second operand is `src_b`.
- R2: funct3=0 in full width gives the 64-bit sum, wrapping. In register form, funct7=0x00 selects add and funct7=0x20 selects `src_a - src_b`. In immediate form the operation is always add, whatever funct7 holds.
- R3: funct3=4 gives XOR, funct3=6 gives OR and funct3=7 gives AND, all in full width.
- R4: funct3=2 compares the two operands as signed numbers and funct3=3 compares them as unsigned numbers. The result is 1 if `src_a` is the smaller value and 0 otherwise, so bits 63:1 are always zero.
- R5: In full width, funct3=1 shifts left and funct3=5 shifts right. The amount is the low 6 bits of the second operand. In register form, funct7=0x00 selects a logical right shift and 0x20 an arithmetic one. In immediate form, funct7[6:1]=000000 selects logical and funct7[6:1]=010000 selects arithmetic, with funct7[0] ignored. A left shift is legal only with that logical code.
- R6: In word mode, funct3=0 adds (or subtracts with funct7=0x20 in register form), keeps the low 32 bits, and sign-extends them from bit 31.
- R7: In word mode, funct3=1 shifts the low 32 bits of `src_a` left and funct3=5 shifts them right, zero-filled with funct7=0x00 and sign-filled from bit 31 with funct7=0x20. The amount is the low 5 bits of the second operand, and the 32-bit result is sign-extended from bit 31. A left word shift needs funct7=0x00.
- R8: Any other combination drives `bad_op`=1 and `result`=0. This covers every funct3 other than 0, 1 and 5 in word mode, and every funct7 not listed above. Every listed combination drives `bad_op`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand, register form |
| imm_val | input | 64 | Sign-extended immediate, immediate form |
| funct3 | input | 3 | Operation group field |
| funct7 | input | 7 | Operation variant field |
| imm_sel | input | 1 | 1 = immediate form, 0 = register form |
| word_op | input | 1 | 1 = 32-bit word operation, 0 = full width |
| result | output | 64 | Operation result |
| bad_op | output | 1 | Unsupported funct3/funct7 pair for the selected form |

## Verification
Two functions act on the same result in one evaluation: the 5-bit amount masking and the bit-31 sign extension of word shifts. The bench provokes both by sweeping every amount from 0 to 127 through SRLW and SRAW. It uses operands whose bit 31 is set and whose upper half disagrees with it, so a zero shift must still come back negative, and amounts of 32 or more must wrap. Legality decoding and operand selection also meet in immediate forms, where funct7 carries immediate bits. A full sweep of forms, funct3 codes and chosen funct7 values is judged against an arithmetic model that sets both the flag and the result.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  typedef enum logic [3:0] {
    OPK_ADD,
    OPK_SUB,
    OPK_SHL,
    OPK_SLT,
    OPK_SLTU,
    OPK_XOR,
    OPK_SHR_L,
    OPK_SHR_A,
    OPK_OR,
    OPK_AND,
    OPK_NONE
  } opkind_e;

  localparam logic [2:0] F3_ADDSUB = 3'd0;
  localparam logic [2:0] F3_SHL    = 3'd1;
  localparam logic [2:0] F3_SLT    = 3'd2;
  localparam logic [2:0] F3_SLTU   = 3'd3;
  localparam logic [2:0] F3_XOR    = 3'd4;
  localparam logic [2:0] F3_SHR    = 3'd5;
  localparam logic [2:0] F3_OR     = 3'd6;
  localparam logic [2:0] F3_AND    = 3'd7;

  localparam logic [6:0] F7_BASE = 7'h00;
  localparam logic [6:0] F7_ALT  = 7'h20;

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
  import int_exec_pkg::*;
(
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  input  logic       imm_sel,
  input  logic       word_op,
  output opkind_e    kind,
  output logic       bad
);

  logic f7_base;
  logic f7_alt;
  logic f6_base;
  logic f6_alt;

  always_comb begin
    f7_base = (funct7 == F7_BASE);
    f7_alt  = (funct7 == F7_ALT);
    f6_base = (funct7[6:1] == F7_BASE[6:1]);
    f6_alt  = (funct7[6:1] == F7_ALT[6:1]);
  end

  always_comb begin
    kind = OPK_NONE;
    unique case (funct3)
      F3_ADDSUB: begin
        if (imm_sel)      kind = OPK_ADD;
        else if (f7_base) kind = OPK_ADD;
        else if (f7_alt)  kind = OPK_SUB;
      end
      F3_SHL: begin
        if (imm_sel && !word_op) begin
          if (f6_base) kind = OPK_SHL;
        end else if (f7_base) begin
          kind = OPK_SHL;
        end
      end
      F3_SHR: begin
        if (imm_sel && !word_op) begin
          if (f6_base)     kind = OPK_SHR_L;
          else if (f6_alt) kind = OPK_SHR_A;
        end else begin
          if (f7_base)     kind = OPK_SHR_L;
          else if (f7_alt) kind = OPK_SHR_A;
        end
      end
      F3_SLT:  if (!word_op && (imm_sel || f7_base)) kind = OPK_SLT;
      F3_SLTU: if (!word_op && (imm_sel || f7_base)) kind = OPK_SLTU;
      F3_XOR:  if (!word_op && (imm_sel || f7_base)) kind = OPK_XOR;
      F3_OR:   if (!word_op && (imm_sel || f7_base)) kind = OPK_OR;
      F3_AND:  if (!word_op && (imm_sel || f7_base)) kind = OPK_AND;
      default: kind = OPK_NONE;
    endcase
  end

  assign bad = (kind == OPK_NONE);

endmodule

// File: rtl/int_exec_addsub.sv
module int_exec_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum
);

  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + {{(W-1){1'b0}}, sub};
  end

  always_comb begin
    if (sub && (a == b))
      a_r2_sub_self_zero : assert (sum == '0)
        else $error("subtract of equal operands is nonzero");
  end

endmodule

// File: rtl/int_exec_compare.sv
module int_exec_compare #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt_s,
  output logic         lt_u
);

  logic [W:0] diff;

  always_comb begin
    diff = {1'b0, a} - {1'b0, b};
    lt_u = diff[W];
    lt_s = (a[W-1] != b[W-1]) ? a[W-1] : diff[W];
  end

  always_comb begin
    if (a == b)
      a_r4_equal_not_less : assert (!lt_s && !lt_u)
        else $error("equal operands compare as less");
  end

endmodule

// File: rtl/int_exec_shift.sv
module int_exec_shift #(
  parameter int W  = 64,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  dout
);

  logic          fill;
  logic [AW:0][W-1:0] stg;

  assign fill   = arith & din[W-1];
  assign stg[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = !amt[k] ? stg[k]
                    : left    ? {stg[k][W-S-1:0], {S{1'b0}}}
                    :           {{S{fill}}, stg[k][W-1:S]};
  end

  assign dout = stg[AW];

  always_comb begin
    if (amt == '0)
      a_r5_zero_shift_passes : assert (dout == din)
        else $error("zero shift altered data");
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] imm_val,
  input  logic [2:0]      funct3,
  input  logic [6:0]      funct7,
  input  logic            imm_sel,
  input  logic            word_op,
  output logic [XLEN-1:0] result,
  output logic            bad_op
);

  localparam int XAW = $clog2(XLEN);
  localparam int WAW = $clog2(WLEN);

  opkind_e         kind;
  logic            dec_bad;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] sum_x;
  logic            lt_s;
  logic            lt_u;
  logic [XLEN-1:0] shx_out;
  logic [WLEN-1:0] shw_out;
  logic            sh_left;
  logic            sh_arith;
  logic [XLEN-1:0] full_res;
  logic [WLEN-1:0] word_low;

  assign opnd_b   = imm_sel ? imm_val : src_b;
  assign sh_left  = (kind == OPK_SHL);
  assign sh_arith = (kind == OPK_SHR_A);

  int_exec_decode u_decode (
    .funct3  (funct3),
    .funct7  (funct7),
    .imm_sel (imm_sel),
    .word_op (word_op),
    .kind    (kind),
    .bad     (dec_bad)
  );

  int_exec_addsub #(.W(XLEN)) u_addsub (
    .a   (src_a),
    .b   (opnd_b),
    .sub (kind == OPK_SUB),
    .sum (sum_x)
  );

  int_exec_compare #(.W(XLEN)) u_cmp (
    .a    (src_a),
    .b    (opnd_b),
    .lt_s (lt_s),
    .lt_u (lt_u)
  );

  int_exec_shift #(.W(XLEN)) u_shift_x (
    .din   (src_a),
    .amt   (opnd_b[XAW-1:0]),
    .left  (sh_left),
    .arith (sh_arith),
    .dout  (shx_out)
  );

  int_exec_shift #(.W(WLEN)) u_shift_w (
    .din   (src_a[WLEN-1:0]),
    .amt   (opnd_b[WAW-1:0]),
    .left  (sh_left),
    .arith (sh_arith),
    .dout  (shw_out)
  );

  always_comb begin
    full_res = '0;
    unique case (kind)
      OPK_ADD, OPK_SUB:    full_res = sum_x;
      OPK_SHL, OPK_SHR_L,
      OPK_SHR_A:           full_res = shx_out;
      OPK_SLT:             full_res = {{(XLEN-1){1'b0}}, lt_s};
      OPK_SLTU:            full_res = {{(XLEN-1){1'b0}}, lt_u};
      OPK_XOR:             full_res = src_a ^ opnd_b;
      OPK_OR:              full_res = src_a | opnd_b;
      OPK_AND:             full_res = src_a & opnd_b;
      default:             full_res = '0;
    endcase
  end

  always_comb begin
    word_low = (kind == OPK_ADD || kind == OPK_SUB) ? sum_x[WLEN-1:0] : shw_out;
  end

  always_comb begin
    if (dec_bad)      result = '0;
    else if (word_op) result = {{(XLEN-WLEN){word_low[WLEN-1]}}, word_low};
    else              result = full_res;
    bad_op = dec_bad;
  end

  always_comb begin
    if (bad_op)
      a_r8_bad_forces_zero : assert (result == '0)
        else $error("illegal encoding produced nonzero result");
    if (word_op && !bad_op)
      a_r7_word_sign_extended : assert (result[XLEN-1:WLEN-1] == '0 || (&result[XLEN-1:WLEN-1]))
        else $error("word result not sign-extended");
    if (!word_op && !bad_op && (funct3 == F3_SLT || funct3 == F3_SLTU))
      a_r4_flag_only_bit0 : assert (result[XLEN-1:1] == '0)
        else $error("compare result has upper bits set");
  end

endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

  logic        clk;
  logic [63:0] src_a, src_b, imm_val;
  logic [2:0]  funct3;
  logic [6:0]  funct7;
  logic        imm_sel, word_op;
  logic [63:0] result;
  logic        bad_op;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int_exec_unit u_int_exec_unit (
    .src_a(src_a), .src_b(src_b), .imm_val(imm_val),
    .funct3(funct3), .funct7(funct7),
    .imm_sel(imm_sel), .word_op(word_op),
    .result(result), .bad_op(bad_op)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  logic [63:0] vals [8];
  logic [6:0]  f7s [6];

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // Reference model written from the requirements. Returns {illegal, value}.
  function automatic logic [64:0] model(input bit w, input bit im, input logic [2:0] f3,
      input logic [6:0] f7, input logic [63:0] a, input logic [63:0] b, input logic [63:0] iv);
    logic [63:0] y;
    logic [31:0] a32;
    int sh;
    y = im ? iv : b;
    a32 = a[31:0];
    if (!w) begin
      sh = int'(y[5:0]);
      case (f3)
        3'd0: if (im || f7 == 7'h00) return {1'b0, a + y};
              else if (f7 == 7'h20) return {1'b0, a - y};
        3'd1: if ((im && f7[6:1] == 6'd0) || (!im && f7 == 7'h00)) return {1'b0, a << sh};
        3'd5: begin
          if ((im && f7[6:1] == 6'd0) || (!im && f7 == 7'h00)) return {1'b0, a >> sh};
          if ((im && f7[6:1] == 6'h10) || (!im && f7 == 7'h20)) return {1'b0, 64'($signed(a) >>> sh)};
        end
        3'd2: if (im || f7 == 7'h00) return {1'b0, 63'd0, $signed(a) < $signed(y)};
        3'd3: if (im || f7 == 7'h00) return {1'b0, 63'd0, a < y};
        3'd4: if (im || f7 == 7'h00) return {1'b0, a ^ y};
        3'd6: if (im || f7 == 7'h00) return {1'b0, a | y};
        3'd7: if (im || f7 == 7'h00) return {1'b0, a & y};
        default: ;
      endcase
    end else begin
      sh = int'(y[4:0]);
      case (f3)
        3'd0: if (im || f7 == 7'h00) return {1'b0, sx32(a32 + y[31:0])};
              else if (f7 == 7'h20) return {1'b0, sx32(a32 - y[31:0])};
        3'd1: if (f7 == 7'h00) return {1'b0, sx32(a32 << sh)};
        3'd5: if (f7 == 7'h00) return {1'b0, sx32(a32 >> sh)};
              else if (f7 == 7'h20) return {1'b0, sx32(32'($signed(a32) >>> sh))};
        default: ;
      endcase
    end
    return {1'b1, 64'd0};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp,
                       input logic gb, input logic eb);
    checks++;
    if (got !== exp || gb !== eb) begin
      failures++;
      $display("FAIL %s: form w=%0b i=%0b f3=%0d f7=%h got result=%h bad=%0b expected result=%h bad=%0b",
               req, word_op, imm_sel, funct3, funct7, got, gb, exp, eb);
    end
  endtask

  function automatic string req_of(input bit w, input logic [2:0] f3, input bit illegal);
    if (illegal) return "R8";
    if (w) return (f3 == 3'd0) ? "R6" : "R7";
    case (f3)
      3'd0: return "R2";
      3'd1, 3'd5: return "R5";
      3'd2, 3'd3: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic apply(input bit w, input bit im, input logic [2:0] f3, input logic [6:0] f7,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] iv,
                       input string force_req);
    logic [64:0] e;
    @(posedge clk);
    word_op = w; imm_sel = im; funct3 = f3; funct7 = f7;
    src_a = a; src_b = b; imm_val = iv;
    @(negedge clk);
    e = model(w, im, f3, f7, a, b, iv);
    check(force_req != "" ? force_req : req_of(w, f3, e[64]), result, e[63:0], bad_op, e[64]);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    vals[0] = 64'h0;                  vals[1] = 64'h1;
    vals[2] = 64'hffff_ffff_ffff_ffff; vals[3] = 64'h8000_0000_0000_0000;
    vals[4] = 64'h7fff_ffff_ffff_ffff; vals[5] = 64'h0000_0000_8000_0000;
    vals[6] = 64'h1234_5678_9abc_def0; vals[7] = 64'h0000_0001_7fff_fffe;
    f7s[0] = 7'h00; f7s[1] = 7'h20; f7s[2] = 7'h01;
    f7s[3] = 7'h7f; f7s[4] = 7'h40; f7s[5] = 7'h21;

    word_op = 0; imm_sel = 0; funct3 = 0; funct7 = 0;
    src_a = 0; src_b = 0; imm_val = 0;

    // Idle state: all-zero inputs are a legal add of zeros (R2)
    @(negedge clk);
    check("R2", result, 64'd0, bad_op, 1'b0);

    // R1: immediate form takes imm_val, src_b ignored; register form takes src_b
    apply(0, 1, 3'd0, 7'h00, 64'd10, 64'hdead_beef_0000_0000, 64'd5, "R1");
    apply(0, 1, 3'd0, 7'h00, 64'd10, 64'h0000_0000_1234_0000, 64'd5, "R1");
    apply(0, 0, 3'd0, 7'h00, 64'd10, 64'd7, 64'd5, "R1");
    apply(0, 1, 3'd4, 7'h00, 64'hff, 64'hffff, 64'hffff_ffff_ffff_fff0, "R1");

    // Sweep over forms, funct3, selected funct7 values and operand pairs
    for (int f = 0; f < 4; f++)
      for (int f3 = 0; f3 < 8; f3++)
        for (int k = 0; k < 6; k++)
          for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
              logic [11:0] i12;
              i12 = {f7s[k][4:0], vals[j][6:0]};
              apply(f[1], f[0], 3'(f3), f7s[k], vals[i], vals[j],
                    {{52{f7s[k][6]}}, f7s[k][6:5], i12[9:0]}, "");
            end

    // Shift amount sweep 0..127: masking to 6 bits (R5) and to 5 bits with sign extension (R7)
    for (int w = 0; w < 2; w++)
      for (int m = 0; m < 3; m++)
        for (int amt = 0; amt < 128; amt++)
          for (int i = 3; i < 8; i++)
            apply(w[0], 0, (m == 0) ? 3'd1 : 3'd5, (m == 2) ? 7'h20 : 7'h00,
                  vals[i], 64'(amt) | 64'hff00_0000_0000_0000, 64'd0, w ? "R7" : "R5");

    // Immediate-form 64-bit shifts with all six amount bits (R5)
    for (int amt = 0; amt < 64; amt++) begin
      apply(0, 1, 3'd1, {6'd0, amt[5]}, vals[6], 64'd0, 64'(amt), "R5");
      apply(0, 1, 3'd5, {6'h10, amt[5]}, vals[3], 64'd0, 64'(amt) | 64'h400, "R5");
      apply(0, 1, 3'd5, {6'd0, amt[5]}, vals[3], 64'd0, 64'(amt), "R5");
    end

    // Word immediate shifts and ADDIW with wrap (R7, R6)
    for (int amt = 0; amt < 32; amt++) begin
      apply(1, 1, 3'd5, 7'h20, vals[5], 64'd0, 64'(amt) | 64'h400, "R7");
      apply(1, 1, 3'd1, 7'h00, vals[7], 64'd0, 64'(amt), "R7");
    end
    apply(1, 1, 3'd0, 7'h00, 64'h0000_0000_7fff_ffff, 64'd0, 64'd1, "R6");
    apply(1, 0, 3'd0, 7'h20, 64'd0, 64'd1, 64'd0, "R6");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule